// File: doc/BRIEF.md
# Pipelined Polar-to-Rectangular Converter

The block turns a polar pair, a signed 16-bit magnitude and an unsigned 16-bit phase, into signed 16-bit real and imaginary parts. The phase is a fraction of a full turn. A value of 0x4000 means a quarter turn and 0x8000 means half a turn. The datapath has a fixed depth. It takes one new pair on every clock and returns each result 20 clocks later.

The datapath works in steps:
- A quadrant swap uses the top two phase bits.
- Sixteen shift-and-add rotation stages follow.
- One constant multiply removes the rotation gain.
- A rounding stage and an output register finish the path.

A table-mode input replaces the magnitude with exactly one. The outputs then carry the cosine and sine of the phase. A range input doubles the weight of every magnitude bit. Any magnitude beyond the square root of two is clipped to that value. A saturation flag goes high together with the result that came from the clipped input.

A valid bit travels alongside the data. Each input register and each output port has its own enable.

Top module: `polar_rect_conv`

## Requirements
- R1: The magnitude and phase input registers load on the rising clock edge while their active-low load enables are low. While a load enable is high, that register keeps its previous value.
- R2: With table mode low and range low, the magnitude LSB weighs 2^-15. The outputs are Q2.14 signed values (LSB 2^-14). The real output is magnitude times cos(2*pi*phase/65536) and the imaginary output is magnitude times the sine of the same angle. Each output is within 2 LSB of the rounded exact value, for negative magnitudes too.
- R3: With range high, each magnitude bit weighs twice as much, so the LSB weighs 2^-14 and the MSB weighs 2^1.
- R4: A scaled magnitude above 46341 * 2^-15 is clipped to +46341 * 2^-15. One below -46341 * 2^-15 is clipped to -46341 * 2^-15. The saturation flag is high in exactly the cycle that carries the result computed from the clipped input, and low for every other result.
- R5: With table mode high, the magnitude input and the range input are ignored and the magnitude is one. The real output is then cos(phase) * 16384 and the imaginary output is sin(phase) * 16384. The saturation flag stays low.
- R6: An input pair is captured at a rising edge. Its result, flag and valid bit appear after the 20th rising edge, counting the capture edge as the first.
- R7: The valid output equals the valid input delayed by 20 clocks. A cycle in which the valid input is low produces no valid output.
- R8: While the real-port disable is high, the real output reads all zeros. While the imaginary-port disable is high, the imaginary output reads all zeros. Neither disable affects the other port or the pipeline.
- R9: A synchronous active-low reset clears all registers. After reset both outputs read zero and the valid and saturation outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| mag_i | input | 16 | Signed magnitude |
| phase_i | input | 16 | Unsigned phase, fraction of a turn |
| mag_ld_n | input | 1 | Magnitude register load enable, active low |
| ph_ld_n | input | 1 | Phase register load enable, active low |
| rng_hi | input | 1 | High: magnitude LSB weighs 2^-14; low: 2^-15 |
| tbl_mode | input | 1 | High: unity magnitude, cosine/sine output |
| vld_i | input | 1 | Valid tag for the current input |
| re_dis | input | 1 | Forces the real output to zero |
| im_dis | input | 1 | Forces the imaginary output to zero |
| re_o | output | 16 | Real part, Q2.14 |
| im_o | output | 16 | Imaginary part, Q2.14 |
| sat_o | output | 1 | Result came from a clipped magnitude |
| vld_o | output | 1 | Valid tag delayed to match the result |

## Verification
The conversion is driven along every octant boundary and at odd angles near a full turn, with half-scale, near-full-scale and negative magnitudes. These patterns separate errors in the quadrant swap from errors in the rotation stages and in the sign handling. Magnitudes one step below and one step above the clip level, in both signs, tell a wrong threshold apart from a wrong flag alignment. A long random stream mixes range, table mode, held load enables and gaps in the valid input. It shows whether held registers, the mode bits and the valid tag stay in step with the data.

// File: rtl/polar_rect_conv.sv
module polar_rect_conv #(
  parameter int W  = 16,
  parameter int ST = 16,
  parameter int G  = 4,
  parameter int ZW = 24,
  parameter int KF = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mag_i,
  input  logic [W-1:0] phase_i,
  input  logic         mag_ld_n,
  input  logic         ph_ld_n,
  input  logic         rng_hi,
  input  logic         tbl_mode,
  input  logic         vld_i,
  input  logic         re_dis,
  input  logic         im_dis,
  output logic [W-1:0] re_o,
  output logic [W-1:0] im_o,
  output logic         sat_o,
  output logic         vld_o
);
  localparam int MW  = W + 2;
  localparam int IW  = MW + G + 2;
  localparam int PW  = IW + KF + 2;
  localparam int ZS  = ZW - W - 2;
  localparam int SH  = G + KF + 1;
  localparam int LAT = ST + 4;
  localparam int CW  = $clog2(LAT + 1);
  // sqrt(2) and one, in units of 2^-(W-1)
  localparam logic signed [MW-1:0] SQ   = MW'(46341);
  localparam logic signed [MW-1:0] UNI  = MW'(32'sd1 <<< (W - 1));
  // inverse rotation gain, KF fraction bits
  localparam logic signed [KF+1:0] KC   = (KF + 2)'(39797);
  localparam logic signed [PW-1:0] RND  = {{(PW - SH){1'b0}}, 1'b1, {(SH - 1){1'b0}}};
  localparam logic signed [PW-1:0] OMAX = PW'(2 ** (W - 1) - 1);
  localparam logic signed [PW-1:0] OMIN = ~OMAX;

  // arctan(2^-i) in units of 2^-(ZW-2) turn
  function automatic logic signed [ZW-1:0] atan_k(input int i);
    case (i)
      0:  return ZW'(524288);
      1:  return ZW'(309505);
      2:  return ZW'(163534);
      3:  return ZW'(83012);
      4:  return ZW'(41667);
      5:  return ZW'(20854);
      6:  return ZW'(10430);
      7:  return ZW'(5215);
      8:  return ZW'(2608);
      9:  return ZW'(1304);
      10: return ZW'(652);
      11: return ZW'(326);
      12: return ZW'(163);
      13: return ZW'(81);
      14: return ZW'(41);
      15: return ZW'(20);
      default: return '0;
    endcase
  endfunction

  function automatic logic [W-1:0] clamp(input logic signed [PW-1:0] v);
    if (v > OMAX)      return OMAX[W-1:0];
    else if (v < OMIN) return OMIN[W-1:0];
    else               return v[W-1:0];
  endfunction

  logic [W-1:0] m_q, p_q;
  logic         rng_q, tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q   <= '0;
      p_q   <= '0;
      rng_q <= 1'b0;
      tbl_q <= 1'b0;
    end else begin
      if (!mag_ld_n) m_q <= mag_i;
      if (!ph_ld_n)  p_q <= phase_i;
      rng_q <= rng_hi;
      tbl_q <= tbl_mode;
    end
  end

  logic signed [MW-1:0] m_ext, m_scl, m_lim;
  logic                 sat_c;

  assign m_ext = MW'($signed(m_q));
  assign m_scl = rng_q ? (m_ext <<< 1) : m_ext;
  assign sat_c = !tbl_q && ((m_scl > SQ) || (m_scl < -SQ));

  always_comb begin
    if (tbl_q)              m_lim = UNI;
    else if (m_scl > SQ)    m_lim = SQ;
    else if (m_scl < -SQ)   m_lim = -SQ;
    else                    m_lim = m_scl;
  end

  logic signed [IW-1:0] m_w, x0, y0;
  logic signed [ZW-1:0] z0;

  assign m_w = IW'(m_lim) <<< G;
  assign z0  = ZW'(p_q[W-3:0]) << ZS;

  always_comb begin
    case (p_q[W-1 -: 2])
      2'd0:    begin x0 = m_w;  y0 = '0;   end
      2'd1:    begin x0 = '0;   y0 = m_w;  end
      2'd2:    begin x0 = -m_w; y0 = '0;   end
      default: begin x0 = '0;   y0 = -m_w; end
    endcase
  end

  for (genvar i = 0; i < ST; i++) begin : g_rot
    logic signed [IW-1:0] xa, ya, xr, yr;
    logic signed [ZW-1:0] za, zr;
    if (i == 0) begin : g_first
      assign xa = x0;
      assign ya = y0;
      assign za = z0;
    end else begin : g_next
      assign xa = g_rot[i-1].xr;
      assign ya = g_rot[i-1].yr;
      assign za = g_rot[i-1].zr;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        xr <= '0;
        yr <= '0;
        zr <= '0;
      end else if (!za[ZW-1]) begin
        xr <= xa - (ya >>> i);
        yr <= ya + (xa >>> i);
        zr <= za - atan_k(i);
      end else begin
        xr <= xa + (ya >>> i);
        yr <= ya - (xa >>> i);
        zr <= za + atan_k(i);
      end
    end
  end

  logic signed [PW-1:0] gx, gy, rxs, rys;
  logic        [W-1:0]  rx, ry, ox, oy;

  assign rxs = (gx + RND) >>> SH;
  assign rys = (gy + RND) >>> SH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gx <= '0;
      gy <= '0;
      rx <= '0;
      ry <= '0;
      ox <= '0;
      oy <= '0;
    end else begin
      gx <= PW'(g_rot[ST-1].xr) * PW'(KC);
      gy <= PW'(g_rot[ST-1].yr) * PW'(KC);
      rx <= clamp(rxs);
      ry <= clamp(rys);
      ox <= rx;
      oy <= ry;
    end
  end

  assign re_o = re_dis ? '0 : ox;
  assign im_o = im_dis ? '0 : oy;

  logic [LAT-1:0] vp;
  logic [LAT-2:0] sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp <= '0;
      sp <= '0;
    end else begin
      vp <= {vp[LAT-2:0], vld_i};
      sp <= {sp[LAT-3:0], sat_c};
    end
  end

  assign vld_o = vp[LAT-1];
  assign sat_o = sp[LAT-2];

  logic [CW-1:0] wc;
  always_ff @(posedge clk) begin
    if (!rst_n)                 wc <= '0;
    else if (wc != CW'(LAT))    wc <= wc + CW'(1);
  end

  logic signed [W:0] ex, ey;
  logic        [W:0] ax, ay;
  assign ex = {ox[W-1], ox};
  assign ey = {oy[W-1], oy};
  assign ax = ex[W] ? -ex : ex;
  assign ay = ey[W] ? -ey : ey;

  AST_MAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mag_ld_n |=> $stable(m_q)); // R1
  AST_PH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ph_ld_n |=> $stable(p_q)); // R1
  AST_AMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (int'(ax) <= int'(SQ >>> 1) + 3) && (int'(ay) <= int'(SQ >>> 1) + 3)); // R4
  AST_SAT_FULL: assert property (@(posedge clk) disable iff (!rst_n) sat_o |-> (int'(ax) + int'(ay) >= int'(SQ >>> 1) - 8)); // R4
  AST_VLD_DELAY: assert property (@(posedge clk) disable iff (!rst_n) (wc == CW'(LAT)) |-> (vld_o == $past(vld_i, LAT))); // R7
endmodule

// File: tb/test_polar_rect_conv.sv
`timescale 1ns/1ps
module test_polar_rect_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mag_i = '0, phase_i = '0;
  logic        mag_ld_n = 1'b0, ph_ld_n = 1'b0, rng_hi = 1'b0, tbl_mode = 1'b0, vld_i = 1'b0;
  logic        re_dis = 1'b0, im_dis = 1'b0;
  logic [15:0] re_o, im_o;
  logic        sat_o, vld_o;

  polar_rect_conv i_polar_rect_conv (
    .clk(clk), .rst_n(rst_n), .mag_i(mag_i), .phase_i(phase_i),
    .mag_ld_n(mag_ld_n), .ph_ld_n(ph_ld_n), .rng_hi(rng_hi), .tbl_mode(tbl_mode),
    .vld_i(vld_i), .re_dis(re_dis), .im_dis(im_dis),
    .re_o(re_o), .im_o(im_o), .sat_o(sat_o), .vld_o(vld_o)
  );

  always #2 clk = ~clk;

  typedef struct {int xr; int xi; bit sat; string req;} exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int hm = 0, hp = 0;
  bit mon_on = 1'b0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic exp_t model(input int m, input int p, input bit rng, input bit tbl, input string req);
    exp_t e;
    int u;
    real mg, th;
    e.sat = 1'b0;
    u = rng ? m * 2 : m;
    if (tbl) u = 32768;
    else if (u > 46341) begin u = 46341; e.sat = 1'b1; end
    else if (u < -46341) begin u = -46341; e.sat = 1'b1; end
    mg = real'(u) / 32768.0;
    th = 6.283185307179586 * real'(p) / 65536.0;
    e.xr = rnd(mg * $cos(th) * 16384.0);
    e.xi = rnd(mg * $sin(th) * 16384.0);
    e.req = req;
    return e;
  endfunction

  task automatic drive(input int m, input int p, input bit mld_n, input bit pld_n,
                       input bit rng, input bit tbl, input bit vld, input string req);
    @(negedge clk);
    mag_i = 16'(m); phase_i = 16'(p);
    mag_ld_n = mld_n; ph_ld_n = pld_n; rng_hi = rng; tbl_mode = tbl; vld_i = vld;
    if (!mld_n) hm = int'($signed(16'(m)));
    if (!pld_n) hp = p & 16'hFFFF;
    if (vld) q.push_back(model(hm, hp, rng, tbl, req));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "");
  endtask

  initial begin : monitor
    exp_t e;
    int ar, ai;
    wait (mon_on);
    forever begin
      @(posedge clk); #1;
      if (vld_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7", "valid without pending input", 1, 0);
        end else begin
          e = q.pop_front();
          ar = int'($signed(re_o));
          ai = int'($signed(im_o));
          if (re_dis) chk(ar == 0, "R8", "real port disabled", ar, 0);
          else        chk(ar - e.xr <= 2 && e.xr - ar <= 2, e.req, "real", ar, e.xr);
          if (im_dis) chk(ai == 0, "R8", "imag port disabled", ai, 0);
          else        chk(ai - e.xi <= 2 && e.xi - ai <= 2, e.req, "imag", ai, e.xi);
          chk(sat_o == e.sat, "R4", "saturation flag", int'(sat_o), int'(e.sat));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin : main
    int ph[10] = '{0, 16'h2000, 16'h4000, 16'h6000, 16'h8000, 16'hA000, 16'hC000, 16'hE000, 16'h1234, 16'hFFFF};
    int n;
    vld_i = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk(vld_o == 1'b0, "R9", "valid during reset", int'(vld_o), 0);
    @(negedge clk);
    rst_n = 1'b1; vld_i = 1'b0; mag_ld_n = 1'b1; ph_ld_n = 1'b1;
    @(posedge clk); #1;
    chk(re_o == 16'h0, "R9", "real after reset", int'(re_o), 0);
    chk(im_o == 16'h0, "R9", "imag after reset", int'(im_o), 0);
    chk(sat_o == 1'b0, "R9", "sat after reset", int'(sat_o), 0);
    chk(vld_o == 1'b0, "R9", "valid after reset", int'(vld_o), 0);
    mon_on = 1'b1;

    // R6 latency from capture edge to valid result
    drive(16384, 16'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6");
    @(posedge clk);
    n = 1;
    @(negedge clk);
    vld_i = 1'b0;
    while (!vld_o && n < 40) begin
      @(posedge clk); #1;
      n++;
    end
    chk(n == 20, "R6", "latency in edges", n, 20);
    idle(3);

    // R2 coordinate conversion, range low
    for (int k = 0; k < 10; k++) drive(16384, ph[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    for (int k = 0; k < 10; k++) drive(32767, ph[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    for (int k = 0; k < 10; k++) drive(-12288, ph[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    drive(-32768, 16'h4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");

    // R3 range high
    for (int k = 0; k < 10; k++) drive(16384, ph[k], 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
    for (int k = 0; k < 10; k++) drive(-8192, ph[k], 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R3");

    // R4 clip boundaries
    drive(23170, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    drive(23171, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    drive(-23170, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    drive(-23171, 16'h4000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    drive(32767, 16'h2000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    drive(-32768, 16'h9000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
    drive(1000, 16'h3000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R4");

    // R5 table mode ignores magnitude and range
    for (int k = 0; k < 10; k++) drive(32767, ph[k], 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5");
    for (int k = 0; k < 10; k++) drive(-5, ph[k], 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R5");

    // R1 load enables hold their register
    drive(16384, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    drive(8000, 16'h3000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    drive(-20000, 16'h7000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
    drive(123, 16'hB000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
    idle(24);

    // R8 output disables while results stream out
    for (int k = 0; k < 10; k++) drive(20000, ph[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    idle(12);
    re_dis = 1'b1;
    idle(10);
    re_dis = 1'b0;
    for (int k = 0; k < 10; k++) drive(-20000, ph[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    idle(12);
    im_dis = 1'b1;
    idle(10);
    im_dis = 1'b0;

    // random mix
    for (int k = 0; k < 400; k++) begin
      int m, p;
      bit ml, pl, rg, tb, vd;
      string rq;
      m  = int'($signed(16'($urandom)));
      p  = int'($urandom & 32'hFFFF);
      ml = ($urandom % 5) == 0;
      pl = ($urandom % 5) == 0;
      rg = $urandom % 2;
      tb = ($urandom % 4) == 0;
      vd = ($urandom % 6) != 0;
      rq = (ml || pl) ? "R1" : (tb ? "R5" : (rg ? "R3" : "R2"));
      drive(m, p, ml, pl, rg, tb, vd, rq);
    end
    idle(30);
    chk(q.size() == 0, "R7", "pending results after drain", q.size(), 0);
    summary();
    $finish;
  end
endmodule